// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers interrupt requests from a set of ordinary peripheral sources and from one dedicated non-maskable source. It drives a single interrupt line and a vector index to a small processor core. Each request input is edge detected into a sticky pending bit. Ordinary sources pass through a per-source enable and a global enable. The non-maskable source ignores both enables and ranks above every ordinary source.

Every ordinary source carries a run-time priority value. Among the eligible pending sources, the one with the highest priority wins, and on a tie the lower source index wins. The winner is offered only if its level is strictly above the level currently in service. While offered, the interrupt line and the vector are held unchanged until the core acknowledges. The acknowledge clears the winner's pending bit, saves the interrupted level on an in-service stack, and makes the winner's level the current one. A return-from-interrupt pulse pops the stack and restores the level that was interrupted.

Vector encoding: the non-maskable source issues vector 0, and ordinary source k issues vector k+1. Priority is numeric, with a larger value ranking higher.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, irq_o is low, vec_o is 0, and the in-service level is idle, so the first request at any priority is offered.
- R2: A rising edge on req_i[k] sets a sticky pending bit at the next clock edge, and irq_o rises one edge later, even if the request was a single-cycle pulse.
- R3: A pending ordinary source with its src_en_i bit at 0, or with glb_en_i at 0, never raises irq_o. The source stays pending and is offered one clock edge after it becomes enabled.
- R4: The non-maskable input nmi_i raises irq_o with vector 0 regardless of src_en_i and glb_en_i. It outranks every ordinary source, including one already in service.
- R5: Among eligible pending sources, the one whose src_prio_i field (bits k*PRIO_W upward) is largest is offered, with vector k+1.
- R6: When several eligible sources share the largest priority, the lowest source index is offered.
- R7: While irq_o is high, vec_o holds its value until the clock edge that samples ack_i high. irq_o is low after that edge.
- R8: An acknowledge clears the pending bit of the offered source, so that source is not offered again without a new rising edge on its request.
- R9: While a level is in service, a pending source at equal or lower priority is not offered. A strictly higher one is offered one edge after the acknowledge that entered the current level.
- R10: A pulse on rti_i restores the level saved by the most recent acknowledge, and nested returns unwind in reverse order. A pulse with nothing in service has no effect.
- R11: When STACK_DEPTH levels are in service, no further source is offered until a return frees a stack entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Ordinary request lines, rising-edge sensitive |
| nmi_i | input | 1 | Non-maskable request line, rising-edge sensitive |
| src_en_i | input | NUM_SRC | Per-source enable, 1 = allowed |
| glb_en_i | input | 1 | Global enable for ordinary sources |
| src_prio_i | input | NUM_SRC*PRIO_W | Priority value of each ordinary source |
| ack_i | input | 1 | Core takes the offered vector (one cycle) |
| rti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | $clog2(NUM_SRC+1) | Vector index of the offered source |

## Verification
A request edge driven before clock edge N is visible as pending at edge N, and irq_o with its vector follows at edge N+1. The bench drives every stimulus on the falling edge and samples one full cycle later for each register on the path. An acknowledge lowers irq_o at the edge that samples it. A waiting source that becomes eligible through an enable, an acknowledge or a return appears one edge later. Checks of absence wait three edges past the earliest due cycle before reading irq_o.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic {
    OFF_IDLE  = 1'b0,
    OFF_SHOWN = 1'b1
  } offer_state_e;
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    assert_edge_sets_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[gi] |=> pend_q[gi]);
    assert_ack_clears_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[gi] && !rise[gi]) |=> !pend_q[gi]);
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int N_ALL  = NUM_SRC + 1,
  localparam int IDX_W  = $clog2(N_ALL),
  localparam int LVL_W  = PRIO_W + 1
) (
  input  logic [N_ALL-1:0]          pend_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic                      glb_en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic [LVL_W-1:0]          cur_lvl_i,
  input  logic                      block_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [LVL_W-1:0]          win_lvl_o
);
  localparam logic [LVL_W-1:0] NMI_LVL = '1;
  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(NUM_SRC);

  logic [NUM_SRC-1:0] elig;
  logic [LVL_W-1:0]   lvl_a [NUM_SRC];
  logic               found;
  logic [LVL_W-1:0]   best_lvl;
  logic [IDX_W-1:0]   best_idx;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    assign elig[gi]  = pend_i[gi] & src_en_i[gi] & glb_en_i;
    assign lvl_a[gi] = LVL_W'(src_prio_i[gi*PRIO_W +: PRIO_W]) + LVL_W'(1);
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      // strict compare keeps the lower index on a tie
      if (elig[k] && (!found || lvl_a[k] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_a[k];
        best_idx = IDX_W'(k);
      end
    end
    if (pend_i[NUM_SRC]) begin
      found    = 1'b1;
      best_lvl = NMI_LVL;
      best_idx = NMI_IDX;
    end
  end

  assign hit_o     = found && (best_lvl > cur_lvl_i) && !block_i;
  assign win_idx_o = best_idx;
  assign win_lvl_o = best_lvl;

  logic [N_ALL-1:0] en_ext;
  assign en_ext = {1'b1, src_en_i & {NUM_SRC{glb_en_i}}};

  always_comb begin
    if (hit_o) begin
      assert_masked_never_wins_R3: assert (en_ext[win_idx_o])
        else $error("masked source selected");
      assert_above_service_level_R9: assert (win_lvl_o > cur_lvl_i)
        else $error("winner not above in-service level");
    end
    for (int k = 0; k < NUM_SRC; k++) begin
      if (hit_o && win_idx_o != NMI_IDX && elig[k]) begin
        assert_winner_ranks_first_R6: assert (lvl_a[k] < win_lvl_o ||
                                              (lvl_a[k] == win_lvl_o && IDX_W'(k) >= win_idx_o))
          else $error("eligible source outranks winner");
      end
    end
  end
endmodule

// File: rtl/ivc_level_stack.sv
module ivc_level_stack #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 4,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             full_o
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] cur_q, top_lvl;
  logic [SP_W-1:0]  sp_q;
  logic             do_pop;

  assign full_o = (sp_q == SP_W'(DEPTH));
  assign do_pop = pop_i && !push_i && (sp_q != '0);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              stk_q[gi] <= '0;
      else if (push_i && sp_q == SP_W'(gi))     stk_q[gi] <= cur_q;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int k = 0; k < DEPTH; k++)
      if (sp_q == SP_W'(k + 1)) top_lvl = stk_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cur_q <= '0;
    end else if (push_i) begin
      sp_q  <= sp_q + SP_W'(1);
      cur_q <= push_lvl_i;
    end else if (do_pop) begin
      sp_q  <= sp_q - SP_W'(1);
      cur_q <= top_lvl;
    end
  end

  assign cur_lvl_o = cur_q;

  assert_push_not_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_restores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pop |=> cur_q == $past(top_lvl));
  assert_empty_is_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_q == '0) |-> (cur_q == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 4,
  localparam int N_ALL      = NUM_SRC + 1,
  localparam int IDX_W      = $clog2(N_ALL),
  localparam int LVL_W      = PRIO_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic                      nmi_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic                      glb_en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic                      ack_i,
  input  logic                      rti_i,
  output logic                      irq_o,
  output logic [IDX_W-1:0]          vec_o
);
  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(NUM_SRC);
  localparam logic [LVL_W-1:0] NMI_LVL = '1;

  offer_state_e     st_q;
  logic [N_ALL-1:0] pend, clr;
  logic             hit, full, take;
  logic [IDX_W-1:0] win_idx, lat_idx_q, lat_vec_q;
  logic [LVL_W-1:0] win_lvl, lat_lvl_q, cur_lvl;

  assign take = (st_q == OFF_SHOWN) && ack_i;
  assign clr  = take ? (N_ALL'(1) << lat_idx_q) : '0;

  ivc_pending #(.N(N_ALL)) i_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  ({nmi_i, req_i}),
    .clr_i  (clr),
    .pend_o (pend)
  );

  ivc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_arbiter (
    .pend_i     (pend),
    .src_en_i   (src_en_i),
    .glb_en_i   (glb_en_i),
    .src_prio_i (src_prio_i),
    .cur_lvl_i  (cur_lvl),
    .block_i    (full),
    .hit_o      (hit),
    .win_idx_o  (win_idx),
    .win_lvl_o  (win_lvl)
  );

  ivc_level_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) i_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_lvl_i (lat_lvl_q),
    .pop_i      (rti_i),
    .cur_lvl_o  (cur_lvl),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= OFF_IDLE;
      lat_idx_q <= '0;
      lat_vec_q <= '0;
      lat_lvl_q <= '0;
    end else begin
      unique case (st_q)
        OFF_IDLE: if (hit) begin
          st_q      <= OFF_SHOWN;
          lat_idx_q <= win_idx;
          lat_lvl_q <= win_lvl;
          lat_vec_q <= (win_idx == NMI_IDX) ? '0 : win_idx + IDX_W'(1);
        end
        OFF_SHOWN: if (ack_i) st_q <= OFF_IDLE;
        default: st_q <= OFF_IDLE;
      endcase
    end
  end

  assign irq_o = (st_q == OFF_SHOWN);
  assign vec_o = lat_vec_q;

  assert_vec_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));
  assert_ack_drops_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !irq_o);
  assert_nmi_offered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && pend[NUM_SRC] && cur_lvl != NMI_LVL && !full) |=> (irq_o && vec_o == '0));
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  localparam int NUM_SRC = 8;
  localparam int PRIO_W  = 3;
  localparam int DEPTH   = 4;
  localparam int VEC_W   = $clog2(NUM_SRC + 1);

  logic                      clk = 1'b0;
  logic                      rst_ni = 1'b0;
  logic [NUM_SRC-1:0]        req = '0;
  logic                      nmi = 1'b0;
  logic [NUM_SRC-1:0]        src_en = '1;
  logic                      glb_en = 1'b1;
  logic [NUM_SRC*PRIO_W-1:0] prio = '0;
  logic                      ack = 1'b0;
  logic                      rti = 1'b0;
  logic                      irq;
  logic [VEC_W-1:0]          vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .STACK_DEPTH(DEPTH)) i_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .nmi_i(nmi), .src_en_i(src_en),
    .glb_en_i(glb_en), .src_prio_i(prio), .ack_i(ack), .rti_i(rti),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_prio(int k, int p);
    prio[k*PRIO_W +: PRIO_W] = PRIO_W'(p);
  endtask

  task automatic pulse(int k);
    req[k] = 1'b1;
    tick();
    req[k] = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic do_rti(int n);
    for (int i = 0; i < n; i++) begin
      rti = 1'b1;
      tick();
      rti = 1'b0;
    end
  endtask

  task automatic wait_quiet(string tag);
    tick(); tick(); tick();
    chk(tag, irq, 0);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", irq, 0);
    chk("R1 vec after reset", vec, 0);
    set_prio(3, 0);
    pulse(3);
    tick();
    chk("R1 lowest prio offered from idle", irq, 1);
    chk("R2 vec for src3", vec, 4);
    do_ack();
    chk("R7 irq drops after ack", irq, 0);
    do_rti(1);
  endtask

  task automatic t_mask();
    set_prio(5, 2);
    src_en[5] = 1'b0;
    pulse(5);
    wait_quiet("R3 masked source quiet");
    src_en[5] = 1'b1;
    tick();
    chk("R3 offered after unmask", irq, 1);
    chk("R3 vec after unmask", vec, 6);
    do_ack(); do_rti(1);
    glb_en = 1'b0;
    set_prio(2, 1);
    pulse(2);
    wait_quiet("R3 global disable quiet");
    glb_en = 1'b1;
    tick();
    chk("R3 vec after global enable", vec, 3);
    do_ack(); do_rti(1);
  endtask

  task automatic t_priority();
    set_prio(1, 3);
    set_prio(6, 5);
    req[1] = 1'b1; req[6] = 1'b1;
    tick();
    req = '0;
    tick();
    chk("R5 highest prio vec", vec, 7);
    do_ack();
    wait_quiet("R9 lower prio waits");
    do_rti(1);
    tick();
    chk("R10 lower offered after return", irq, 1);
    chk("R10 vec after return", vec, 2);
    do_ack(); do_rti(1);
  endtask

  task automatic t_tie();
    set_prio(2, 4);
    set_prio(4, 4);
    req[2] = 1'b1; req[4] = 1'b1;
    tick();
    req = '0;
    tick();
    chk("R6 tie lower index", vec, 3);
    do_ack();
    wait_quiet("R9 equal prio waits");
    do_rti(1);
    tick();
    chk("R6 second of tie", vec, 5);
    do_ack(); do_rti(1);
  endtask

  task automatic t_hold_and_nest();
    set_prio(0, 1);
    set_prio(7, 7);
    pulse(0);
    tick();
    chk("R2 single pulse offered", vec, 1);
    pulse(7);
    tick(); tick();
    chk("R7 irq held", irq, 1);
    chk("R7 vec held", vec, 1);
    do_ack();
    chk("R7 irq low at ack edge", irq, 0);
    tick();
    chk("R9 higher preempts", vec, 8);
    do_ack();
    do_rti(2);
    wait_quiet("R8 acked sources not reoffered");
  endtask

  task automatic t_nmi();
    set_prio(3, 7);
    pulse(3);
    tick();
    do_ack();
    src_en = '0;
    glb_en = 1'b0;
    pulse_nmi();
    tick();
    chk("R4 nmi irq", irq, 1);
    chk("R4 nmi vec", vec, 0);
    do_ack();
    do_rti(2);
    src_en = '1;
    glb_en = 1'b1;
    wait_quiet("R10 extra return harmless");
    do_rti(1);
    set_prio(1, 0);
    pulse(1);
    tick();
    chk("R10 idle after unwind", vec, 2);
    do_ack(); do_rti(1);
  endtask

  task automatic t_depth();
    for (int k = 0; k < DEPTH; k++) begin
      set_prio(k, k);
      pulse(k);
      tick();
      chk("R11 nested level offered", vec, k + 1);
      do_ack();
    end
    set_prio(DEPTH, DEPTH);
    pulse(DEPTH);
    wait_quiet("R11 full stack blocks");
    do_rti(1);
    tick();
    chk("R11 offered after return", vec, DEPTH + 1);
    do_ack();
    do_rti(DEPTH + 1);
    wait_quiet("R8 nothing left pending");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_mask();
    t_priority();
    t_tie();
    t_hold_and_nest();
    t_nmi();
    t_depth();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule